// File: doc/BRIEF.md
# Interrupt Controller Command Word Sequencer

This block is the programming front end of an eight-level interrupt controller. It watches a small processor-side register port: an active-low select, active-low read and write strobes, one address bit and a byte-wide data bus. It works out what each write means and keeps the resulting mode configuration. A write on the low address with data bit 4 set always starts a new setup sequence. The following writes on the high address are taken as the vector base, then an optional cascade word, then an optional options word. Which of the optional words are expected depends on flags carried in the first word.

Once setup is complete, the block leaves the sequence. High-address writes then load the interrupt mask. Low-address writes with bit 4 clear are steered by bit 3: when bit 3 is 0 they are end-of-interrupt/rotation commands, and when bit 3 is 1 they are read-select/poll/special-mask commands. The end-of-interrupt/rotation commands and poll requests leave the block as one-cycle strobes for the priority logic, which lives elsewhere.

Reads return one of three registers. A high-address read returns the mask. A low-address read returns the request or in-service vector, both supplied from outside, as chosen by the last read-select command.

Top module: `cw_init_seq`

## Requirements
- R1: After reset `ready` is 0 and every configuration output is 0, with `imr` = 0. A low-address read returns `irr_in`.
- R2: A write with `a0`=0 and `din[4]`=1 starts the setup sequence from any state. It latches `ltim`=din[3], `adi`=din[2], `sngl`=din[1] and `ic4`=din[0], and drops `ready`.
- R3: That same write also does the following: clears `imr` and `smm`, sets `cas_map` to 8'h07, and points low-address reads at `irr_in`. It pulses `init_clr` high for one cycle. When din[0]=0 it clears `sfnm`, `buf_mode`, `master`, `aeoi` and `upm`.
- R4: The first `a0`=1 write after the start word loads `vec_base` from din[7:3].
- R5: A cascade word (`a0`=1, loaded into `cas_map`) is expected only when `sngl`=0. An options word is expected only when `ic4`=1. `ready` rises with the last required word.
- R6: The options word sets `upm`=din[0], `aeoi`=din[1], `buf_mode`=din[3] and `sfnm`=din[4]. It sets `master`=din[2] only when din[3]=1; otherwise `master` is 0.
- R7: With `ready`=1, an `a0`=1 write loads `imr` from din, where 1 = masked.
- R8: With `ready`=1, a write with `a0`=0, din[4]=0 and din[3]=0 raises `op2_stb` for one cycle. It carries `op2_cmd`=din[7:5] and `op2_lvl`=din[2:0].
- R9: With `ready`=1, a write with `a0`=0, din[4]=0 and din[3]=1 is the read/poll word. din[6]=1 copies din[5] into `smm`; din[6]=0 leaves `smm` unchanged. din[1]=1 copies din[0] into the read select (1 = in-service). din[2]=1 pulses `poll_stb` for one cycle.
- R10: While `cs_n` and `rd_n` are both low, `dout` shows `imr` when `a0`=1. When `a0`=0 it shows `irr_in` or `isr_in`, per the read select. At all other times `dout` is 0.
- R11: A write strobe while `cs_n` is high changes no state.
- R12: Command writes that arrive out of place are ignored. This covers a write with `a0`=0 and din[4]=0 before `ready`, and an `a0`=1 write before any start word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Register port select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, one cycle per write |
| a0 | input | 1 | Register address bit |
| din | input | DW | Write data |
| irr_in | input | DW | Request vector from the request logic |
| isr_in | input | DW | In-service vector from the service logic |
| dout | output | DW | Read data, 0 when not reading |
| ready | output | 1 | Setup sequence complete |
| init_clr | output | 1 | One-cycle pulse: clear edge-sense and reset rotation so level 7 is lowest |
| ltim | output | 1 | Level-triggered requests |
| adi | output | 1 | Call address interval flag |
| sngl | output | 1 | Single device (no cascade) |
| ic4 | output | 1 | Options word expected |
| vec_base | output | DW-3 | Vector base bits |
| cas_map | output | DW | Slave map (master) or slave identity |
| sfnm | output | 1 | Special fully nested mode |
| buf_mode | output | 1 | Buffered mode |
| master | output | 1 | Master in buffered mode |
| aeoi | output | 1 | Automatic end of interrupt |
| upm | output | 1 | Processor mode flag |
| smm | output | 1 | Special mask mode |
| imr | output | DW | Interrupt mask |
| op2_stb | output | 1 | End-of-interrupt/rotation command strobe |
| op2_cmd | output | 3 | Command bits of that word |
| op2_lvl | output | 3 | Level bits of that word |
| poll_stb | output | 1 | Poll command strobe |

## Verification
The assertions assume that every access is a synchronous strobe lasting one clock, that read and write are never asserted together, and that `din` and `a0` are steady for the strobe cycle. They also assume that at most one write lands per cycle, so at most one of the command pulses can fire. The stimulus keeps to this by changing all inputs only on the falling clock edge. Each write or read is held low for exactly one cycle, and accesses are issued back to back, with setup sequences restarted in the middle of operation.

// File: rtl/pic_cw_pkg.sv
// Shared types for the command word sequencer.
// Assumes an eight-level controller with byte-wide command words.
package pic_cw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // never set up
        ST_W2,     // waiting for vector base word
        ST_W3,     // waiting for cascade word
        ST_W4,     // waiting for options word
        ST_RUN     // setup complete
    } seq_state_e;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_INIT1,  // start word
        WK_ADDR1,  // high-address write
        WK_OP2,    // end-of-interrupt / rotation word
        WK_OP3     // read / poll / special mask word
    } wr_kind_e;
endpackage

// File: rtl/cw_decode.sv
// Classifies the current bus cycle as one kind of write.
// Assumes one-cycle synchronous write strobes; no state is kept here.
module cw_decode
    import pic_cw_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          a0,
    input  logic [DW-1:0] din,
    output wr_kind_e      wkind
);
    // Purpose: map select, address and marker bits to a write kind.
    always_comb begin
        wkind = WK_NONE;
        if (!cs_n && !wr_n) begin
            if (a0)          wkind = WK_ADDR1;
            else if (din[4]) wkind = WK_INIT1;
            else if (din[3]) wkind = WK_OP3;
            else             wkind = WK_OP2;
        end
    end
endmodule

// File: rtl/cw_seq.sv
// Setup sequence state machine and mode configuration registers.
// Assumes at most one classified write per cycle from cw_decode.
module cw_seq
    import pic_cw_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wr_kind_e      wkind,
    input  logic [DW-1:0] din,
    output logic          ready,
    output logic          init_clr,
    output logic          ltim,
    output logic          adi,
    output logic          sngl,
    output logic          ic4,
    output logic [DW-4:0] vec_base,
    output logic [DW-1:0] cas_map,
    output logic          sfnm,
    output logic          buf_mode,
    output logic          master,
    output logic          aeoi,
    output logic          upm,
    output logic          smm,
    output logic          rd_isr,
    output logic [DW-1:0] imr,
    output logic          op2_stb,
    output logic [2:0]    op2_cmd,
    output logic [2:0]    op2_lvl,
    output logic          poll_stb
);
    localparam logic [DW-1:0] SLAVE_DEFAULT = DW'(7);

    seq_state_e state;

    assign ready = (state == ST_RUN);

    // Purpose: advance the setup sequence and update configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            init_clr <= 1'b0;
            ltim     <= 1'b0;
            adi      <= 1'b0;
            sngl     <= 1'b0;
            ic4      <= 1'b0;
            vec_base <= '0;
            cas_map  <= '0;
            sfnm     <= 1'b0;
            buf_mode <= 1'b0;
            master   <= 1'b0;
            aeoi     <= 1'b0;
            upm      <= 1'b0;
            smm      <= 1'b0;
            rd_isr   <= 1'b0;
            imr      <= '0;
            op2_stb  <= 1'b0;
            op2_cmd  <= '0;
            op2_lvl  <= '0;
            poll_stb <= 1'b0;
        end else begin
            init_clr <= 1'b0;
            op2_stb  <= 1'b0;
            poll_stb <= 1'b0;
            if (wkind == WK_INIT1) begin
                state    <= ST_W2;
                init_clr <= 1'b1;
                ltim     <= din[3];
                adi      <= din[2];
                sngl     <= din[1];
                ic4      <= din[0];
                imr      <= '0;
                cas_map  <= SLAVE_DEFAULT;
                smm      <= 1'b0;
                rd_isr   <= 1'b0;
                if (!din[0]) begin
                    sfnm     <= 1'b0;
                    buf_mode <= 1'b0;
                    master   <= 1'b0;
                    aeoi     <= 1'b0;
                    upm      <= 1'b0;
                end
            end else if (wkind == WK_ADDR1) begin
                case (state)
                    ST_W2: begin
                        vec_base <= din[DW-1:3];
                        if (!sngl)    state <= ST_W3;
                        else if (ic4) state <= ST_W4;
                        else          state <= ST_RUN;
                    end
                    ST_W3: begin
                        cas_map <= din;
                        state   <= ic4 ? ST_W4 : ST_RUN;
                    end
                    ST_W4: begin
                        sfnm     <= din[4];
                        buf_mode <= din[3];
                        master   <= din[2] & din[3];
                        aeoi     <= din[1];
                        upm      <= din[0];
                        state    <= ST_RUN;
                    end
                    ST_RUN:  imr <= din;
                    default: ;
                endcase
            end else if (wkind == WK_OP2 && state == ST_RUN) begin
                op2_stb <= 1'b1;
                op2_cmd <= din[7:5];
                op2_lvl <= din[2:0];
            end else if (wkind == WK_OP3 && state == ST_RUN) begin
                if (din[6]) smm    <= din[5];
                if (din[1]) rd_isr <= din[0];
                poll_stb <= din[2];
            end
        end
    end

    // R2: a start word always lands in the vector-base step
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wkind == WK_INIT1 |=> state == ST_W2 && init_clr);

    // R3: start word side effects
    a_r3_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        wkind == WK_INIT1 |=> imr == '0 && !smm && !rd_isr && cas_map == SLAVE_DEFAULT);

    // R5: single device without options word is ready after the vector base
    a_r5_short_seq: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_W2 && wkind == WK_ADDR1 && sngl && !ic4 |=> ready);

    // R7: mask moves only on a mask write or a start word
    a_r7_imr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wkind == WK_ADDR1 && state == ST_RUN) && wkind != WK_INIT1 |=> $stable(imr));

    // R12: command words before setup completes raise no strobe
    a_r12_early_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (wkind == WK_OP2 || wkind == WK_OP3) && state != ST_RUN |=> !op2_stb && !poll_stb);

    // R9: at most one command pulse per cycle
    a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op2_stb, poll_stb, init_clr}));
endmodule

// File: rtl/cw_status.sv
// Status read multiplexer for mask, request and in-service vectors.
// Assumes read strobes are synchronous and never overlap writes.
module cw_status #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          a0,
    input  logic          rd_isr,
    input  logic [DW-1:0] imr,
    input  logic [DW-1:0] irr_in,
    input  logic [DW-1:0] isr_in,
    output logic [DW-1:0] dout
);
    // Purpose: drive the selected register only during a selected read.
    always_comb begin
        dout = '0;
        if (!cs_n && !rd_n) begin
            if (a0)          dout = imr;
            else if (rd_isr) dout = isr_in;
            else             dout = irr_in;
        end
    end

    // R10: a mask read reflects the mask register
    a_r10_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n && !rd_n && a0 |-> dout == imr);
endmodule

// File: rtl/cw_init_seq.sv
// Top of the command word sequencer: decode, sequence, status read.
// Assumes one-cycle synchronous bus strobes on clk.
module cw_init_seq
    import pic_cw_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          a0,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] irr_in,
    input  logic [DW-1:0] isr_in,
    output logic [DW-1:0] dout,
    output logic          ready,
    output logic          init_clr,
    output logic          ltim,
    output logic          adi,
    output logic          sngl,
    output logic          ic4,
    output logic [DW-4:0] vec_base,
    output logic [DW-1:0] cas_map,
    output logic          sfnm,
    output logic          buf_mode,
    output logic          master,
    output logic          aeoi,
    output logic          upm,
    output logic          smm,
    output logic [DW-1:0] imr,
    output logic          op2_stb,
    output logic [2:0]    op2_cmd,
    output logic [2:0]    op2_lvl,
    output logic          poll_stb
);
    wr_kind_e wkind;
    logic     rd_isr;

    cw_decode #(.DW(DW)) u_dec (
        .cs_n(cs_n), .wr_n(wr_n), .a0(a0), .din(din), .wkind(wkind)
    );

    cw_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .wkind(wkind), .din(din),
        .ready(ready), .init_clr(init_clr), .ltim(ltim), .adi(adi),
        .sngl(sngl), .ic4(ic4), .vec_base(vec_base), .cas_map(cas_map),
        .sfnm(sfnm), .buf_mode(buf_mode), .master(master), .aeoi(aeoi),
        .upm(upm), .smm(smm), .rd_isr(rd_isr), .imr(imr),
        .op2_stb(op2_stb), .op2_cmd(op2_cmd), .op2_lvl(op2_lvl),
        .poll_stb(poll_stb)
    );

    cw_status #(.DW(DW)) u_sts (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .a0(a0),
        .rd_isr(rd_isr), .imr(imr), .irr_in(irr_in), .isr_in(isr_in),
        .dout(dout)
    );

    // R11: an unselected write leaves the mask alone
    a_r11_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(imr) && !init_clr);
endmodule

// File: tb/sim_cw_init_seq.sv
// Scoreboard bench: the driver queues expectations with each access,
// the monitor compares them just after the capturing clock edge.
module sim_cw_init_seq;
    localparam int  PERIOD = 10;
    localparam int  DW     = 8;
    localparam int  S_READY = 0, S_CFG1 = 1, S_VEC = 2, S_CAS = 3, S_W4 = 4,
                    S_SMM = 5, S_IMR = 6, S_OP2 = 7, S_POLL = 8, S_DOUT = 9,
                    S_ICLR = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] irr_in = 8'hA5, isr_in = 8'h3C;
    logic [DW-1:0] dout, cas_map, imr;
    logic [DW-4:0] vec_base;
    logic          ready, init_clr, ltim, adi, sngl, ic4, sfnm, buf_mode;
    logic          master, aeoi, upm, smm, op2_stb, poll_stb;
    logic [2:0]    op2_cmd, op2_lvl;

    int     checks = 0, failures = 0;
    bit     done = 1'b0;
    string  q_req[$];
    int     q_sel[$];
    logic [31:0] q_exp[$];

    always #(PERIOD/2) clk = ~clk;

    cw_init_seq #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .din(din), .irr_in(irr_in), .isr_in(isr_in), .dout(dout),
        .ready(ready), .init_clr(init_clr), .ltim(ltim), .adi(adi),
        .sngl(sngl), .ic4(ic4), .vec_base(vec_base), .cas_map(cas_map),
        .sfnm(sfnm), .buf_mode(buf_mode), .master(master), .aeoi(aeoi),
        .upm(upm), .smm(smm), .imr(imr), .op2_stb(op2_stb),
        .op2_cmd(op2_cmd), .op2_lvl(op2_lvl), .poll_stb(poll_stb)
    );

    function automatic logic [31:0] obs(int s);
        case (s)
            S_READY: return 32'(ready);
            S_CFG1:  return 32'({ltim, adi, sngl, ic4});
            S_VEC:   return 32'(vec_base);
            S_CAS:   return 32'(cas_map);
            S_W4:    return 32'({sfnm, buf_mode, master, aeoi, upm});
            S_SMM:   return 32'(smm);
            S_IMR:   return 32'(imr);
            S_OP2:   return 32'({op2_stb, op2_cmd, op2_lvl});
            S_POLL:  return 32'(poll_stb);
            S_DOUT:  return 32'(dout);
            S_ICLR:  return 32'(init_clr);
            default: return 32'hDEAD;
        endcase
    endfunction

    task automatic expect_v(string rq, int sel, logic [31:0] ev);
        q_req.push_back(rq);
        q_sel.push_back(sel);
        q_exp.push_back(ev);
    endtask

    // Monitor: pop every queued expectation just after the capture edge.
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            while (q_sel.size() > 0) begin
                string       rq;
                int          sel;
                logic [31:0] ev, av;
                rq  = q_req.pop_front();
                sel = q_sel.pop_front();
                ev  = q_exp.pop_front();
                av  = obs(sel);
                checks++;
                if (av !== ev) begin
                    failures++;
                    $display("FAIL %s sel=%0d actual=%0h expected=%0h", rq, sel, av, ev);
                end
            end
        end
    end

    // Driver: start an access at the falling edge; the caller queues checks.
    task automatic start_wr(bit sel_n, bit addr, logic [7:0] d);
        cs_n = sel_n; wr_n = 1'b0; rd_n = 1'b1; a0 = addr; din = d;
    endtask

    task automatic start_rd(bit sel_n, bit addr);
        cs_n = sel_n; rd_n = 1'b0; wr_n = 1'b1; a0 = addr;
    endtask

    task automatic finish_cycle();
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; a0 = 1'b0; din = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        expect_v("R1", S_READY, 0); expect_v("R1", S_IMR, 0);
        expect_v("R1", S_CFG1, 0);  expect_v("R1", S_W4, 0);
        start_rd(1'b0, 1'b0); expect_v("R1", S_DOUT, 32'hA5); finish_cycle();
        // R12: mask write before any start word is ignored
        start_wr(1'b0, 1'b1, 8'hFF); finish_cycle();
        expect_v("R12", S_IMR, 0); expect_v("R12", S_READY, 0); finish_cycle();
        // R2: start word, level, interval, single, options expected
        start_wr(1'b0, 1'b0, 8'h1F);
        expect_v("R2", S_CFG1, 4'hF); expect_v("R3", S_ICLR, 1);
        expect_v("R2", S_READY, 0); finish_cycle();
        // R4: vector base
        start_wr(1'b0, 1'b1, 8'hA8);
        expect_v("R4", S_VEC, 5'h15); expect_v("R5", S_READY, 0); finish_cycle();
        // R12: command word during setup is ignored
        start_wr(1'b0, 1'b0, 8'h20); expect_v("R12", S_OP2, 0); finish_cycle();
        // R6: options word with buffered master
        start_wr(1'b0, 1'b1, 8'h1F);
        expect_v("R6", S_W4, 5'h1F); expect_v("R5", S_READY, 1); finish_cycle();
        // R7: mask write and read-back (R10)
        start_wr(1'b0, 1'b1, 8'h5A); expect_v("R7", S_IMR, 8'h5A); finish_cycle();
        start_rd(1'b0, 1'b1); expect_v("R10", S_DOUT, 8'h5A); finish_cycle();
        // R8: end-of-interrupt / rotation word, then strobe drops
        start_wr(1'b0, 1'b0, 8'h63); expect_v("R8", S_OP2, 7'h5B); finish_cycle();
        expect_v("R8", S_OP2, 7'h1B); finish_cycle();
        // R9: special mask set, ignored without enable, then cleared
        start_wr(1'b0, 1'b0, 8'h68); expect_v("R9", S_SMM, 1); finish_cycle();
        start_wr(1'b0, 1'b0, 8'h08); expect_v("R9", S_SMM, 1); finish_cycle();
        start_wr(1'b0, 1'b0, 8'h48); expect_v("R9", S_SMM, 0); finish_cycle();
        // R9: select in-service for reads (R10)
        start_wr(1'b0, 1'b0, 8'h0B); finish_cycle();
        start_rd(1'b0, 1'b0); expect_v("R10", S_DOUT, 8'h3C); finish_cycle();
        // R9: poll pulse
        start_wr(1'b0, 1'b0, 8'h0C); expect_v("R9", S_POLL, 1); finish_cycle();
        expect_v("R9", S_POLL, 0); finish_cycle();
        // R11: unselected write and read
        start_wr(1'b1, 1'b1, 8'h00); finish_cycle();
        expect_v("R11", S_IMR, 8'h5A); finish_cycle();
        start_rd(1'b1, 1'b1); expect_v("R10", S_DOUT, 0); finish_cycle();
        // R2/R3: restart mid-run with special mask and in-service select set
        start_wr(1'b0, 1'b0, 8'h68); finish_cycle();
        start_wr(1'b0, 1'b0, 8'h12);
        expect_v("R2", S_CFG1, 4'h2); expect_v("R3", S_IMR, 0);
        expect_v("R3", S_SMM, 0); expect_v("R3", S_W4, 0);
        expect_v("R3", S_CAS, 8'h07); expect_v("R2", S_READY, 0);
        finish_cycle();
        start_rd(1'b0, 1'b0); expect_v("R3", S_DOUT, 8'hA5); finish_cycle();
        start_wr(1'b0, 1'b1, 8'h40);
        expect_v("R4", S_VEC, 5'h08); expect_v("R5", S_READY, 1); finish_cycle();
        // R5/R6: cascade with options, master bit without buffering
        start_wr(1'b0, 1'b0, 8'h11); finish_cycle();
        start_wr(1'b0, 1'b1, 8'h20); expect_v("R5", S_READY, 0); finish_cycle();
        start_wr(1'b0, 1'b1, 8'h81);
        expect_v("R5", S_CAS, 8'h81); expect_v("R5", S_READY, 0); finish_cycle();
        start_wr(1'b0, 1'b1, 8'h04);
        expect_v("R6", S_W4, 0); expect_v("R5", S_READY, 1); finish_cycle();
        // R5: cascade without options word
        start_wr(1'b0, 1'b0, 8'h10); finish_cycle();
        start_wr(1'b0, 1'b1, 8'h00); expect_v("R5", S_READY, 0); finish_cycle();
        start_wr(1'b0, 1'b1, 8'h24);
        expect_v("R5", S_CAS, 8'h24); expect_v("R5", S_READY, 1); finish_cycle();
        // R10: idle bus reads zero
        expect_v("R10", S_DOUT, 0); finish_cycle();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule